// File: doc/BRIEF.md
# ALU and Compare Execution Unit

This block is the combinational datapath core of a small 32-bit processor's execute stage. It takes two operands, a 4-bit operation code and a 2-bit mode. The mode selects how the code is read. Two modes run arithmetic and logic operations, one with a register as the second operand and one with a sign-extended immediate. A third mode evaluates a condition and returns it as a 0/1 word. A fourth mode evaluates the same condition and returns it as a single taken bit.

The caller reads registers, extends immediates and updates the program counter. This unit only computes values and decisions. The same condition table serves both compare and branch modes, so a compare instruction and a conditional branch with the same code always agree. Codes that are not defined for the selected mode return zero and raise the illegal output, which the decoder can use to trap.

Top module: `exu_alu_cmp`

## Requirements
- R1: Mode encoding is 00 register ALU, 01 immediate ALU, 10 compare, 11 branch. In both ALU modes, code 0000 gives a+b and code 0001 gives a-b, both wrapping modulo 2^32.
- R2: In both ALU modes, the logic codes are 0100 AND, 0101 OR, 0110 XOR, 1100 NAND, 1101 NOR and 1110 XNOR, applied bitwise.
- R3: In immediate ALU mode only, code 1011 is move-high. The result has b[15:0] in bits [31:16] and zero in bits [15:0].
- R4: In compare mode the result is 1 when the condition holds and 0 otherwise, with bits [31:1] always zero.
- R5: The condition codes are:
  - 0000 false, 1000 true
  - 0001 a==b, 1001 a!=b
  - 0010 a<b, 1010 a>=b
  - 0011 a<=b, 1011 a>b
  - 0101 a==0, 1101 a!=0
  - 0110 a<0, 1110 a>=0
  - 0111 a<=0, 1111 a>0
- R6: The compare-with-zero codes (0101, 0110, 0111, 1101, 1110, 1111) ignore operand b completely.
- R7: In branch mode, taken_o carries the condition and result_o is zero. In every other mode, taken_o is 0.
- R8: Code 0000 never branches and code 1000 always branches, for any operands.
- R9: Reserved codes return result_o=0 and taken_o=0 with illegal_o=1. The reserved codes are 0100 and 1100 in compare and branch modes, every unlisted code in the ALU modes, and 1011 in register ALU mode. In all other cases illegal_o is 0.
- R10: All ordering comparisons treat the operands as signed two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Operation mode (see R1) |
| op_code_i | input | 4 | Operation or condition code |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand or sign-extended immediate |
| result_o | output | 32 | ALU result or 0/1 compare word |
| taken_o | output | 1 | Branch decision (branch mode only) |
| illegal_o | output | 1 | Reserved code flag |

## Verification
The bench builds the unit with its default width of 32 bits and a half-width of 16. At that width, the sign boundary at 0x80000000 and 0x7fffffff and the wrap at all-ones are the values that matter. Every mode and code pair is swept over these edge operands, over equal pairs and over random pairs. Each result is compared against a behavioural model. Directed checks then vary b alone for the zero-form conditions and test the signed ordering across the sign boundary.

// File: rtl/exu_alu_cmp_pkg.sv
package exu_alu_cmp_pkg;
  typedef enum logic [1:0] {
    MODE_ALU_REG = 2'b00,
    MODE_ALU_IMM = 2'b01,
    MODE_CMP     = 2'b10,
    MODE_BRANCH  = 2'b11
  } exu_mode_e;

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_SUB  = 4'b0001;
  localparam logic [3:0] OP_AND  = 4'b0100;
  localparam logic [3:0] OP_OR   = 4'b0101;
  localparam logic [3:0] OP_XOR  = 4'b0110;
  localparam logic [3:0] OP_NAND = 4'b1100;
  localparam logic [3:0] OP_NOR  = 4'b1101;
  localparam logic [3:0] OP_XNOR = 4'b1110;
  localparam logic [3:0] OP_MVHI = 4'b1011;

  // condition code fields: [3] invert, [2] compare against zero, [1:0] relation
  typedef enum logic [1:0] {
    REL_NONE = 2'b00,
    REL_EQ   = 2'b01,
    REL_LT   = 2'b10,
    REL_LE   = 2'b11
  } exu_rel_e;
endpackage

// File: rtl/exu_arith.sv
module exu_arith
  import exu_alu_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        code_i,
  input  logic              imm_mode_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bad_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sum, diff, logic_raw, mvhi;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign mvhi = {b_i[HALF_W-1:0], {(DATA_W-HALF_W){1'b0}}};

  // base logic function on code[1:0]; code[3] inverts it
  always_comb begin
    case (code_i[1:0])
      2'b00:   logic_raw = a_i & b_i;
      2'b01:   logic_raw = a_i | b_i;
      2'b10:   logic_raw = a_i ^ b_i;
      default: logic_raw = '0;
    endcase
  end

  always_comb begin
    res_o = '0;
    bad_o = 1'b0;
    case (code_i)
      OP_ADD:  res_o = sum;
      OP_SUB:  res_o = diff;
      OP_AND, OP_OR, OP_XOR:   res_o = logic_raw;
      OP_NAND, OP_NOR, OP_XNOR: res_o = ~logic_raw;
      OP_MVHI: begin
        if (imm_mode_i) res_o = mvhi;
        else            bad_o = 1'b1;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_alu_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        code_i,
  output logic              hit_o,
  output logic              bad_o
);
  logic [DATA_W-1:0] rhs;
  logic              is_eq, is_lt, base;
  exu_rel_e          rel;

  assign rel   = exu_rel_e'(code_i[1:0]);
  assign rhs   = code_i[2] ? '0 : b_i;
  assign is_eq = (a_i == rhs);
  assign is_lt = ($signed(a_i) < $signed(rhs));

  always_comb begin
    case (rel)
      REL_EQ:  base = is_eq;
      REL_LT:  base = is_lt;
      REL_LE:  base = is_lt | is_eq;
      default: base = 1'b0;
    endcase
  end

  // relation "none" with the zero flag set has no meaning
  assign bad_o = (rel == REL_NONE) && code_i[2];
  assign hit_o = bad_o ? 1'b0 : (base ^ code_i[3]);
endmodule

// File: rtl/exu_alu_cmp.sv
module exu_alu_cmp
  import exu_alu_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        mode_i,
  input  logic [3:0]        op_code_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              taken_o,
  output logic              illegal_o
);
  exu_mode_e         mode;
  logic [DATA_W-1:0] alu_res;
  logic              alu_bad, cond_hit, cond_bad;

  assign mode = exu_mode_e'(mode_i);

  exu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i        (src_a_i),
    .b_i        (src_b_i),
    .code_i     (op_code_i),
    .imm_mode_i (mode == MODE_ALU_IMM),
    .res_o      (alu_res),
    .bad_o      (alu_bad)
  );

  exu_cond #(.DATA_W(DATA_W)) u_cond (
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .code_i (op_code_i),
    .hit_o  (cond_hit),
    .bad_o  (cond_bad)
  );

  always_comb begin
    result_o  = '0;
    taken_o   = 1'b0;
    illegal_o = 1'b0;
    case (mode)
      MODE_ALU_REG, MODE_ALU_IMM: begin
        illegal_o = alu_bad;
        result_o  = alu_bad ? '0 : alu_res;
      end
      MODE_CMP: begin
        illegal_o = cond_bad;
        result_o  = {{(DATA_W-1){1'b0}}, cond_hit};
      end
      default: begin
        illegal_o = cond_bad;
        taken_o   = cond_hit;
      end
    endcase
  end
endmodule

// File: rtl/exu_alu_cmp_chk.sv
module exu_alu_cmp_chk #(
  parameter int DATA_W = 32
) (
  input logic [1:0]        mode_i,
  input logic [3:0]        op_code_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              taken_o,
  input logic              illegal_o
);
  logic known;
  assign known = !$isunknown({mode_i, op_code_i, src_a_i, src_b_i});

  always_comb begin
    if (known) begin
      // R9: a flagged code yields no value and no branch
      assert_illegal_quiet_R9: assert (!illegal_o || (result_o == '0 && !taken_o));
      // R4: compare word is 0 or 1
      assert_cmp_word_R4: assert (mode_i != 2'b10 || result_o[DATA_W-1:1] == '0);
      // R7: taken only in branch mode; branch result is zero
      assert_taken_mode_R7: assert (mode_i == 2'b11 || !taken_o);
      assert_branch_res_R7: assert (mode_i != 2'b11 || result_o == '0);
      // R8: constant conditions in branch mode
      assert_true_taken_R8: assert (!(mode_i == 2'b11 && op_code_i == 4'b1000) || taken_o);
      assert_false_idle_R8: assert (!(mode_i == 2'b11 && op_code_i == 4'b0000) || !taken_o);
      // R3: move-high leaves the low half clear
      assert_mvhi_low_R3: assert (!(mode_i == 2'b01 && op_code_i == 4'b1011)
                                  || result_o[DATA_W/2-1:0] == '0);
      // R6: zero test with a==0 holds regardless of b
      assert_eqz_R6: assert (!(mode_i == 2'b10 && op_code_i == 4'b0101 && src_a_i == '0)
                             || result_o == {{(DATA_W-1){1'b0}}, 1'b1});
    end
  end
endmodule

bind exu_alu_cmp exu_alu_cmp_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_exu_alu_cmp.sv
module test_exu_alu_cmp;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode;
  logic [3:0]   code;
  logic [W-1:0] a, b;
  logic [W-1:0] result;
  logic         taken, illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  exu_alu_cmp #(.DATA_W(W)) i_exu_alu_cmp (
    .mode_i(mode), .op_code_i(code), .src_a_i(a), .src_b_i(b),
    .result_o(result), .taken_o(taken), .illegal_o(illegal)
  );

  function automatic string req_tag(input logic [1:0] m, input logic [3:0] c, input bit ill);
    if (ill) return "R9";
    if (m[1]) begin
      if (c == 4'b0000 || c == 4'b1000) return "R8";
      if (c[2]) return "R6";
      return (m == 2'b11) ? "R7" : "R5";
    end
    if (c == 4'b1011) return "R3";
    if (c[3:1] == 3'b000) return "R1";
    return "R2";
  endfunction

  // behavioural reference
  task automatic model(input logic [1:0] m, input logic [3:0] c,
                       input logic [W-1:0] x, input logic [W-1:0] y,
                       output logic [W-1:0] r, output logic t, output logic ill);
    bit cond;
    r = '0; t = 1'b0; ill = 1'b0; cond = 0;
    if (m[1] == 1'b0) begin
      case (c)
        4'd0:  r = x + y;
        4'd1:  r = x - y;
        4'd4:  r = x & y;
        4'd5:  r = x | y;
        4'd6:  r = x ^ y;
        4'd12: r = ~(x & y);
        4'd13: r = ~(x | y);
        4'd14: r = ~(x ^ y);
        4'd11: if (m == 2'b01) r = y << 16; else ill = 1'b1;
        default: ill = 1'b1;
      endcase
    end else begin
      case (c)
        4'd0:  cond = 0;
        4'd1:  cond = (x == y);
        4'd2:  cond = ($signed(x) < $signed(y));
        4'd3:  cond = ($signed(x) <= $signed(y));
        4'd5:  cond = (x == 0);
        4'd6:  cond = ($signed(x) < 0);
        4'd7:  cond = ($signed(x) <= 0);
        4'd8:  cond = 1;
        4'd9:  cond = (x != y);
        4'd10: cond = ($signed(x) >= $signed(y));
        4'd11: cond = ($signed(x) > $signed(y));
        4'd13: cond = (x != 0);
        4'd14: cond = ($signed(x) >= 0);
        4'd15: cond = ($signed(x) > 0);
        default: ill = 1'b1;
      endcase
      if (!ill) begin
        if (m == 2'b10) r = {31'b0, cond};
        else            t = cond;
      end
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (mode=%b code=%b a=%h b=%h)",
               req, what, got, exp, mode, code, a, b);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [3:0] c,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] er; logic et, ei; string tag;
    @(posedge clk);
    mode = m; code = c; a = x; b = y;
    @(negedge clk);
    model(m, c, x, y, er, et, ei);
    tag = req_tag(m, c, ei);
    check(tag, "result", result, er);
    check(tag, "taken", {31'b0, taken}, {31'b0, et});
    check(ei ? "R9" : tag, "illegal", {31'b0, illegal}, {31'b0, ei});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] edges [8];
    logic [W-1:0] r1, r2; logic t1, t2;
    edges[0] = 32'h0; edges[1] = 32'h1; edges[2] = 32'hffffffff; edges[3] = 32'h80000000;
    edges[4] = 32'h7fffffff; edges[5] = 32'h0000ffff; edges[6] = 32'h12345678; edges[7] = 32'hfffffffe;
    mode = 2'b00; code = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs give an all-zero, legal output (R1)
    check("R1", "reset result", result, '0);
    check("R9", "reset illegal", {31'b0, illegal}, '0);
    rst_n = 1'b1;

    // full sweep of modes and codes over edge operands (R1..R10)
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 16; c++) begin
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            apply(m[1:0], c[3:0], edges[i], edges[j]);
        for (int k = 0; k < 10; k++)
          apply(m[1:0], c[3:0], $urandom, $urandom);
      end

    // R6: zero-form conditions unaffected by b
    for (int c = 5; c < 16; c++) begin
      if (c[1:0] == 2'b00 || !c[2]) continue;
      for (int i = 0; i < 8; i++) begin
        apply(2'b10, c[3:0], edges[i], 32'h0);          r1 = result;
        apply(2'b11, c[3:0], edges[i], 32'h0);          t1 = taken;
        apply(2'b10, c[3:0], edges[i], 32'h80000001);   r2 = result;
        apply(2'b11, c[3:0], edges[i], 32'hdeadbeef);   t2 = taken;
        check("R6", "b-independent compare", r2, r1);
        check("R6", "b-independent branch", {31'b0, t2}, {31'b0, t1});
      end
    end

    // R10: signed ordering across the sign boundary
    apply(2'b10, 4'b0010, 32'h80000000, 32'h1);
    check("R10", "min < 1", result, 32'h1);
    apply(2'b11, 4'b1011, 32'h7fffffff, 32'hffffffff);
    check("R10", "max > -1", {31'b0, taken}, 32'h1);
    // R3: move-high directed
    apply(2'b01, 4'b1011, 32'hffffffff, 32'hffffabcd);
    check("R3", "mvhi", result, 32'habcd0000);
    // R1: wrap
    apply(2'b00, 4'b0000, 32'hffffffff, 32'h2);
    check("R1", "add wrap", result, 32'h1);
    // R8: constants
    apply(2'b11, 4'b1000, 32'h0, 32'h5);
    check("R8", "true taken", {31'b0, taken}, 32'h1);
    apply(2'b11, 4'b0000, 32'h5, 32'h5);
    check("R8", "false idle", {31'b0, taken}, 32'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule